// File: doc/BRIEF.md
# Multi-Pin Input Debounce Filter

This block removes noise from six general-purpose input pins. Each raw pin level first goes through a two-flop synchronizer. On an enabled pin, the synchronized level is then filtered. A new level reaches the filtered output only after the same value has been captured on three consecutive sampling ticks. A shorter run is dropped as noise. Sampling ticks come from a one-cycle `sample_en` strobe made by an external clock-selection source. Clock cycles without that strobe are not counted.

A byte-wide configuration register holds one enable bit per pin. When a pin is disabled, its output follows the synchronized input directly. While `stop_mode` is high, every pin is bypassed in the same way. When `stop_mode` falls, filtering resumes from the current synchronized level, so the output does not glitch on the switch.

Each pin runs a small state machine with three states:
- BYPASS: the output is the synchronized input.
- STABLE: the output holds a committed level.
- TRACK: a candidate level is being counted.

The transitions are:
- *arm*: BYPASS to STABLE, when filtering becomes active. The current synchronized level is loaded as the committed level.
- *suspend*: STABLE or TRACK to BYPASS, when the enable bit is 0 or `stop_mode` is 1.
- *start*: STABLE to TRACK, when a tick samples a level that differs from the committed one.
- *drop*: TRACK to STABLE, when a tick samples the committed level again.
- *commit*: TRACK to STABLE, on the third consecutive matching sample. The candidate becomes the output.

Top module: `pin_debounce_filter`

## Requirements
- R1: After reset, `reg_rdata` reads 8'h00 and every pin is bypassed. `pin_out` equals the synchronized input, so it reads 0 during reset and follows a high pin two clocks after reset is released, with no false transition.
- R2: A write with `reg_we` high loads `reg_wdata[5:0]` on that clock edge. Bit i (1 = filter, 0 = bypass) controls pin i. Bits 7:6 always read 0, and writes to them are ignored.
- R3: On a disabled pin, `pin_out[i]` follows `pin_in[i]` after the two-flop synchronizer. A change set up before clock edge k is visible after edge k+1.
- R4: On an enabled pin with `sample_en` held high, a level change set up before edge k appears on `pin_out` after edge k+4. That is the third consecutive tick that sees the new level.
- R5: On an enabled pin, runs of one or two samples are rejected, and so is a pattern that alternates on every cycle. `pin_out` keeps its committed level.
- R6: Only cycles with `sample_en` high count as samples. With the strobe low, a changed input never reaches an enabled pin's output. With pulsed strobes, the level commits on the third pulse.
- R7: While `stop_mode` is 1, all pins behave as in R3 regardless of their enable bits. After release, filtering resumes from the current level without an output change, and short pulses are rejected again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_en | input | 1 | One-cycle sampling tick from the external clock-selection source |
| stop_mode | input | 1 | High while the chip is in stop mode; forces bypass on all pins |
| pin_in | input | 6 | Raw, asynchronous pin levels |
| reg_we | input | 1 | Configuration register write strobe |
| reg_wdata | input | 8 | Configuration write data |
| reg_rdata | output | 8 | Configuration register read value |
| pin_out | output | 6 | Filtered (or bypassed) pin levels |

## Verification
The assertions assume three things about the inputs:
- `sample_en` and `stop_mode` are synchronous to `clk`.
- `stop_mode` holds for at least two cycles, so the bypass check compares against a settled state.
- A register write is a single-cycle strobe.

The stimulus drives every input at the falling edge, keeps stop windows several cycles long, and pulses `sample_en` for exactly one cycle in the strobe test. Raw pin changes are likewise made at the falling edge. The synchronizer therefore sees a clean level, and the assertions do not need to model metastability.

// File: rtl/pdf_pkg.sv
package pdf_pkg;

    typedef enum logic [1:0] {
        ST_BYPASS = 2'd0,
        ST_STABLE = 2'd1,
        ST_TRACK  = 2'd2
    } lane_state_e;

endpackage

// File: rtl/pdf_sync.sv
module pdf_sync #(
    parameter int WIDTH  = 6,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] stg_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg_q[0] <= '0;
        end else begin
            stg_q[0] <= d_i;
        end
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stg_q[s] <= '0;
            end else begin
                stg_q[s] <= stg_q[s-1];
            end
        end
    end

    assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/pdf_cfg_reg.sv
module pdf_cfg_reg #(
    parameter int DW    = 8,
    parameter int NPINS = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic [DW-1:0]    wdata_i,
    output logic [DW-1:0]    rdata_o,
    output logic [NPINS-1:0] en_o
);

    localparam logic [DW-1:0] WMASK = DW'((1 << NPINS) - 1);

    logic [DW-1:0] cfg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (we_i) begin
            cfg_q <= wdata_i & WMASK;
        end
    end

    assign rdata_o = cfg_q;
    assign en_o    = cfg_q[NPINS-1:0];

    AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> rdata_o[NPINS-1:0] == $past(wdata_i[NPINS-1:0])); // R2
    AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> rdata_o[DW-1:NPINS] == '0); // R2

endmodule

// File: rtl/pdf_lane.sv
module pdf_lane
    import pdf_pkg::*;
#(
    parameter int MATCH = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sample_en,
    input  logic filt_on,
    input  logic sync_in,
    output logic pin_o
);

    localparam int CW = $clog2(MATCH + 1);

    lane_state_e    state_q, state_d;
    logic           out_q, out_d;
    logic           cand_q, cand_d;
    logic [CW-1:0]  cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_BYPASS;
            out_q   <= 1'b0;
            cand_q  <= 1'b0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            out_q   <= out_d;
            cand_q  <= cand_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        out_d   = out_q;
        cand_d  = cand_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_BYPASS: begin
                out_d = sync_in;
                if (filt_on) begin
                    state_d = ST_STABLE;            // arm
                end
            end
            ST_STABLE: begin
                if (!filt_on) begin
                    state_d = ST_BYPASS;            // suspend
                    out_d   = sync_in;
                end else if (sample_en && (sync_in != out_q)) begin
                    state_d = ST_TRACK;             // start
                    cand_d  = sync_in;
                    cnt_d   = CW'(1);
                end
            end
            ST_TRACK: begin
                if (!filt_on) begin
                    state_d = ST_BYPASS;            // suspend
                    out_d   = sync_in;
                end else if (sample_en) begin
                    if (sync_in != cand_q) begin
                        state_d = ST_STABLE;        // drop
                    end else if (cnt_q == CW'(MATCH - 1)) begin
                        state_d = ST_STABLE;        // commit
                        out_d   = cand_q;
                    end else begin
                        cnt_d = cnt_q + CW'(1);
                    end
                end
            end
            default: begin
                state_d = ST_BYPASS;
                out_d   = sync_in;
            end
        endcase
    end

    always_comb begin
        pin_o = (state_q == ST_BYPASS) ? sync_in : out_q;
    end

    AST_DISABLED_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (!filt_on && !$past(filt_on)) |-> (pin_o == sync_in)); // R3
    AST_STABLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STABLE && filt_on) |=> (out_q == $past(out_q))); // R5
    AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_BYPASS && filt_on && !sample_en) |=> $stable(out_q)); // R6

endmodule

// File: rtl/pin_debounce_filter.sv
module pin_debounce_filter #(
    parameter int NPINS       = 6,
    parameter int DW          = 8,
    parameter int SYNC_STAGES = 2,
    parameter int MATCH       = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sample_en,
    input  logic             stop_mode,
    input  logic [NPINS-1:0] pin_in,
    input  logic             reg_we,
    input  logic [DW-1:0]    reg_wdata,
    output logic [DW-1:0]    reg_rdata,
    output logic [NPINS-1:0] pin_out
);

    logic [NPINS-1:0] sync_q;
    logic [NPINS-1:0] en_bits;

    pdf_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pin_in),
        .q_o   (sync_q)
    );

    pdf_cfg_reg #(.DW(DW), .NPINS(NPINS)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (reg_we),
        .wdata_i (reg_wdata),
        .rdata_o (reg_rdata),
        .en_o    (en_bits)
    );

    for (genvar i = 0; i < NPINS; i++) begin : g_lane
        pdf_lane #(.MATCH(MATCH)) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .sample_en (sample_en),
            .filt_on   (en_bits[i] & ~stop_mode),
            .sync_in   (sync_q[i]),
            .pin_o     (pin_out[i])
        );
    end

    AST_STOP_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(stop_mode) && stop_mode) |-> (pin_out == sync_q)); // R7

endmodule

// File: tb/pin_debounce_filter_bench.sv
module pin_debounce_filter_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sample_en = 1'b1;
    logic       stop_mode = 1'b0;
    logic [5:0] pin_in = '0;
    logic       reg_we = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [5:0] pin_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Vector table: pins 0..3 filtered, 4..5 bypassed (cfg 8'h0F), sample_en high
    localparam logic [5:0] V_PIN [NV] = '{6'h3F, 6'h3F, 6'h00, 6'h3F, 6'h3C,
                                          6'h3C, 6'h3D, 6'h3C, 6'h3D, 6'h3C};
    localparam int         V_N   [NV] = '{2, 3, 2, 6, 3, 2, 1, 1, 1, 5};
    localparam logic [5:0] V_EXP [NV] = '{6'h30, 6'h3F, 6'h0F, 6'h3F, 6'h3F,
                                          6'h3C, 6'h3C, 6'h3C, 6'h3C, 6'h3C};

    pin_debounce_filter u_pin_debounce_filter (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample_en (sample_en),
        .stop_mode (stop_mode),
        .pin_in    (pin_in),
        .reg_we    (reg_we),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .pin_out   (pin_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic edges(input int n);
        for (int k = 0; k < n; k++) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic write_cfg(input logic [7:0] v);
        reg_we    = 1'b1;
        reg_wdata = v;
        edges(1);
        reg_we    = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        edges(3);
        chk("R1 rdata in reset", reg_rdata, 8'h00);
        chk("R1 pin_out in reset", {2'b00, pin_out}, 8'h00);
        rst_n = 1'b1;
        edges(2);
        chk("R1 pin_out after reset", {2'b00, pin_out}, 8'h00);

        // R2: configure pins 0..3 filtered
        write_cfg(8'h0F);
        chk("R2 cfg readback", reg_rdata, 8'h0F);
        edges(3);

        // Table walk: R3 bypass pins, R4 commit timing, R5 rejection
        for (int i = 0; i < NV; i++) begin
            pin_in = V_PIN[i];
            edges(V_N[i]);
            if (i == 0 || i == 2)
                chk($sformatf("R3 vector %0d", i), {2'b00, pin_out}, {2'b00, V_EXP[i]});
            else if (i == 1 || i == 4 || i == 5)
                chk($sformatf("R4 vector %0d", i), {2'b00, pin_out}, {2'b00, V_EXP[i]});
            else
                chk($sformatf("R5 vector %0d", i), {2'b00, pin_out}, {2'b00, V_EXP[i]});
        end

        // R2: unused bits ignored
        write_cfg(8'hFF);
        chk("R2 unused bits read 0", reg_rdata, 8'h3F);
        edges(3);
        chk("R2 all enabled holds", {2'b00, pin_out}, 8'h3C);

        // R6: no ticks, no change; commit on third pulse
        sample_en = 1'b0;
        pin_in = 6'h00;
        edges(10);
        chk("R6 no tick hold", {2'b00, pin_out}, 8'h3C);
        for (int p = 0; p < 3; p++) begin
            sample_en = 1'b1;
            edges(1);
            sample_en = 1'b0;
            if (p < 2) begin
                chk("R6 before third pulse", {2'b00, pin_out}, 8'h3C);
                edges(3);
            end else begin
                chk("R6 on third pulse", {2'b00, pin_out}, 8'h00);
            end
        end
        sample_en = 1'b1;
        edges(2);

        // R7: stop mode bypass and restore
        stop_mode = 1'b1;
        edges(2);
        pin_in = 6'h3F;
        edges(2);
        chk("R7 stop bypass", {2'b00, pin_out}, 8'h3F);
        stop_mode = 1'b0;
        edges(2);
        chk("R7 release no glitch", {2'b00, pin_out}, 8'h3F);
        pin_in = 6'h00;
        edges(2);
        pin_in = 6'h3F;
        edges(6);
        chk("R7 filter restored", {2'b00, pin_out}, 8'h3F);

        // R1: reset with high pins
        rst_n = 1'b0;
        edges(2);
        chk("R1 rdata cleared", reg_rdata, 8'h00);
        chk("R1 out low in reset", {2'b00, pin_out}, 8'h00);
        rst_n = 1'b1;
        edges(2);
        chk("R1 follows high after reset", {2'b00, pin_out}, 8'h3F);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule